// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block supplies the cross-port interrupt signalling for a two-port shared memory of 1K x 8. The two highest locations serve as mailboxes. When one port writes its mailbox location, the other port receives an active-low interrupt. That interrupt stays asserted until the receiving port reads the same location.

The block observes each port's chip enable, output enable, write strobe and address on every clock edge. It also takes in each port's busy status, which an arbiter elsewhere computes. While a port's busy is asserted, its accesses can neither raise nor clear a flag. The memory array and the collision arbiter are outside this block.

Address assignment: the highest address (all ones, 0x3FF for 10 bits) signals toward the right port. The address below it (0x3FE) signals toward the left port.

Top module: `mbx_irq_flags`

## Requirements
- R1: After reset both interrupt outputs `irq_l_n` and `irq_r_n` are high (inactive).
- R2: A left write qualifies when `l_en_n`=0, `l_we_n`=0, `l_addr`=0x3FF and `l_busy_n`=1. Such a write drives `irq_r_n` low from the clock edge that samples it.
- R3: A right read qualifies when `r_en_n`=0, `r_oe_n`=0, `r_we_n`=1, `r_addr`=0x3FF and `r_busy_n`=1. Such a read returns `irq_r_n` high from the sampling edge.
- R4: A right write qualifies when `r_en_n`=0, `r_we_n`=0, `r_addr`=0x3FE and `r_busy_n`=1. Such a write drives `irq_l_n` low from the sampling edge.
- R5: A left read qualifies when `l_en_n`=0, `l_oe_n`=0, `l_we_n`=1, `l_addr`=0x3FE and `l_busy_n`=1. Such a read returns `irq_l_n` high from the sampling edge.
- R6: An access whose own port has busy low (`l_busy_n`=0 or `r_busy_n`=0) changes no flag, whether the access would set or clear one.
- R7: None of the following changes a flag:
  - any access to an address other than 0x3FE or 0x3FF;
  - any cycle with enable high;
  - a read with output enable high;
  - a read of a port's own sending address;
  - a write to a port's own receiving address.
- R8: If a qualifying set and a qualifying clear of the same flag are sampled on the same edge, the flag ends up set (low).
- R9: The two flags are independent. Both can be set on the same edge, and each holds its value while no qualifying access occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_en_n | input | 1 | Left port chip enable, active low |
| l_oe_n | input | 1 | Left port output enable, active low |
| l_we_n | input | 1 | Left port write strobe: 0 write, 1 read |
| l_addr | input | 10 | Left port address |
| l_busy_n | input | 1 | Left port busy from arbiter, active low |
| r_en_n | input | 1 | Right port chip enable, active low |
| r_oe_n | input | 1 | Right port output enable, active low |
| r_we_n | input | 1 | Right port write strobe: 0 write, 1 read |
| r_addr | input | 10 | Right port address |
| r_busy_n | input | 1 | Right port busy from arbiter, active low |
| irq_l_n | output | 1 | Interrupt to left port, active low |
| irq_r_n | output | 1 | Interrupt to right port, active low |

## Verification
A flag can be set and cleared on the same edge. This happens when the sender writes the mailbox while the receiver is reading it. The bench provokes this by driving both ports to the same mailbox address in one cycle, once with the flag already pending and once with it idle. It then checks that the interrupt output is low after that edge in both cases. Busy-gated accesses are also placed against opposite-port activity, to show that a gated clear does not remove a pending message.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

    // Decoded request of one port toward the flag logic
    typedef struct packed {
        logic raise;   // qualifying write to the peer's mailbox
        logic ack;     // qualifying read of this port's own mailbox
    } mbx_req_t;

    // Registered state of one interrupt flag
    typedef struct packed {
        logic pend;    // 1 = message waiting, interrupt asserted
    } mbx_flag_t;

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_irq_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int SEND_OFS = 0,   // offset below top address written to signal peer
    parameter int RECV_OFS = 1    // offset below top address read to acknowledge
) (
    input  logic              en_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy_n,
    output mbx_req_t          req
);
    localparam logic [ADDR_W-1:0] TOP_A  = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] SEND_A = TOP_A - ADDR_W'(SEND_OFS);
    localparam logic [ADDR_W-1:0] RECV_A = TOP_A - ADDR_W'(RECV_OFS);

    logic granted;
    logic wr_cyc;
    logic rd_cyc;

    always_comb begin
        granted   = !en_n && busy_n;
        wr_cyc    = granted && !we_n;
        rd_cyc    = granted && we_n && !oe_n;
        req.raise = wr_cyc && (addr == SEND_A);
        req.ack   = rd_cyc && (addr == RECV_A);
    end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag
    import mbx_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n
);
    mbx_flag_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (clr_i) state_d.pend = 1'b0;
        if (set_i) state_d.pend = 1'b1;   // set after clear: set wins
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign irq_n = !state_q.pend;
endmodule

// File: rtl/mbx_irq_flags.sv
module mbx_irq_flags
    import mbx_irq_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en_n,
    input  logic              l_oe_n,
    input  logic              l_we_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_busy_n,
    input  logic              r_en_n,
    input  logic              r_oe_n,
    input  logic              r_we_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_busy_n,
    output logic              irq_l_n,
    output logic              irq_r_n
);
    localparam int NPORT = 2;
    localparam int LEFT  = 0;
    localparam int RIGHT = 1;

    logic              en_n   [NPORT];
    logic              oe_n   [NPORT];
    logic              we_n   [NPORT];
    logic [ADDR_W-1:0] addr   [NPORT];
    logic              busy_n [NPORT];
    mbx_req_t          req    [NPORT];
    logic              irq_n  [NPORT];

    always_comb begin
        en_n[LEFT]    = l_en_n;    en_n[RIGHT]   = r_en_n;
        oe_n[LEFT]    = l_oe_n;    oe_n[RIGHT]   = r_oe_n;
        we_n[LEFT]    = l_we_n;    we_n[RIGHT]   = r_we_n;
        addr[LEFT]    = l_addr;    addr[RIGHT]   = r_addr;
        busy_n[LEFT]  = l_busy_n;  busy_n[RIGHT] = r_busy_n;
    end

    // Left sends through the top address and receives at top-1;
    // right is the mirror image.
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        mbx_port_decode #(
            .ADDR_W   (ADDR_W),
            .SEND_OFS ((p == LEFT) ? 0 : 1),
            .RECV_OFS ((p == LEFT) ? 1 : 0)
        ) dec_i (
            .en_n   (en_n[p]),
            .oe_n   (oe_n[p]),
            .we_n   (we_n[p]),
            .addr   (addr[p]),
            .busy_n (busy_n[p]),
            .req    (req[p])
        );

        // Flag of port p is raised by the other port, acknowledged by p
        mbx_flag flag_i (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (req[NPORT-1-p].raise),
            .clr_i (req[p].ack),
            .irq_n (irq_n[p])
        );
    end

    assign irq_l_n = irq_n[LEFT];
    assign irq_r_n = irq_n[RIGHT];
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_en_n,
    input logic              l_oe_n,
    input logic              l_we_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_busy_n,
    input logic              r_en_n,
    input logic              r_oe_n,
    input logic              r_we_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_busy_n,
    input logic              irq_l_n,
    input logic              irq_r_n
);
    localparam logic [ADDR_W-1:0] A_HI = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] A_LO = A_HI - 1'b1;

    logic l_to_r, r_ack, r_to_l, l_ack;
    assign l_to_r = !l_en_n && !l_we_n && l_addr == A_HI && l_busy_n;
    assign r_ack  = !r_en_n && !r_oe_n && r_we_n && r_addr == A_HI && r_busy_n;
    assign r_to_l = !r_en_n && !r_we_n && r_addr == A_LO && r_busy_n;
    assign l_ack  = !l_en_n && !l_oe_n && l_we_n && l_addr == A_LO && l_busy_n;

    // R2 R8
    right_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l_to_r |=> !irq_r_n);
    // R3
    right_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_ack && !l_to_r) |=> irq_r_n);
    // R4 R8
    left_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_to_l |=> !irq_l_n);
    // R5
    left_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_ack && !r_to_l) |=> irq_l_n);
    // R6 R7 R9
    right_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_to_r && !r_ack) |=> $stable(irq_r_n));
    // R6 R7 R9
    left_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_to_l && !l_ack) |=> $stable(irq_l_n));
endmodule

bind mbx_irq_flags mbx_irq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .l_en_n(l_en_n), .l_oe_n(l_oe_n), .l_we_n(l_we_n), .l_addr(l_addr), .l_busy_n(l_busy_n),
    .r_en_n(r_en_n), .r_oe_n(r_oe_n), .r_we_n(r_we_n), .r_addr(r_addr), .r_busy_n(r_busy_n),
    .irq_l_n(irq_l_n), .irq_r_n(irq_r_n)
);

// File: tb/mbx_irq_flags_tb.sv
module mbx_irq_flags_tb_top;
    localparam int AW = 10;
    localparam logic [AW-1:0] HI = 10'h3FF;
    localparam logic [AW-1:0] LO = 10'h3FE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_en_n = 1'b1, l_oe_n = 1'b1, l_we_n = 1'b1, l_busy_n = 1'b1;
    logic r_en_n = 1'b1, r_oe_n = 1'b1, r_we_n = 1'b1, r_busy_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic irq_l_n, irq_r_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = !clk;

    mbx_irq_flags #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .l_en_n(l_en_n), .l_oe_n(l_oe_n), .l_we_n(l_we_n), .l_addr(l_addr), .l_busy_n(l_busy_n),
        .r_en_n(r_en_n), .r_oe_n(r_oe_n), .r_we_n(r_we_n), .r_addr(r_addr), .r_busy_n(r_busy_n),
        .irq_l_n(irq_l_n), .irq_r_n(irq_r_n)
    );

    task automatic idle();
        l_en_n = 1; l_oe_n = 1; l_we_n = 1; l_busy_n = 1; l_addr = '0;
        r_en_n = 1; r_oe_n = 1; r_we_n = 1; r_busy_n = 1; r_addr = '0;
    endtask

    // kind: 0 none, 1 write, 2 read (oe low), 3 read with oe high
    task automatic drv_l(int kind, logic [AW-1:0] a, logic busy_n);
        l_en_n = (kind == 0); l_we_n = (kind != 1); l_oe_n = (kind != 2);
        l_addr = a; l_busy_n = busy_n;
    endtask

    task automatic drv_r(int kind, logic [AW-1:0] a, logic busy_n);
        r_en_n = (kind == 0); r_we_n = (kind != 1); r_oe_n = (kind != 2);
        r_addr = a; r_busy_n = busy_n;
    endtask

    // one edge samples the driven access; return to idle at the next falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic check(string req, logic exp_l, logic exp_r);
        checks++;
        if (irq_l_n !== exp_l || irq_r_n !== exp_r) begin
            fails++;
            $display("FAIL %s: irq_l_n/irq_r_n actual %b/%b expected %b/%b",
                     req, irq_l_n, irq_r_n, exp_l, exp_r);
        end
    endtask

    task automatic t_reset();
        check("R1", 1, 1);
    endtask

    task automatic t_left_to_right();
        drv_l(1, HI, 1); step(); check("R2", 1, 0);
        step();               check("R9", 1, 0);
        drv_r(3, HI, 1); step(); check("R7", 1, 0);
        drv_r(2, HI, 1); step(); check("R3", 1, 1);
    endtask

    task automatic t_right_to_left();
        drv_r(1, LO, 1); step(); check("R4", 0, 1);
        drv_l(2, LO, 1); step(); check("R5", 1, 1);
    endtask

    task automatic t_busy();
        drv_l(1, HI, 0); step(); check("R6", 1, 1);
        drv_r(1, LO, 0); step(); check("R6", 1, 1);
        drv_l(1, HI, 1); drv_r(1, LO, 1); step(); check("R9", 0, 0);
        drv_r(2, HI, 0); drv_l(2, LO, 0); step(); check("R6", 0, 0);
        drv_r(2, HI, 1); drv_l(2, LO, 1); step(); check("R3", 1, 1);
    endtask

    task automatic t_other();
        drv_l(1, 10'h3FD, 1); drv_r(1, 10'h000, 1); step(); check("R7", 1, 1);
        drv_l(0, HI, 1); drv_r(0, LO, 1);
        l_we_n = 0; r_we_n = 0; step(); check("R7", 1, 1);
        drv_l(1, LO, 1); drv_r(1, HI, 1); step(); check("R7", 1, 1);
        drv_l(1, HI, 1); drv_r(1, LO, 1); step();
        drv_l(2, HI, 1); drv_r(2, LO, 1); step(); check("R7", 0, 0);
        drv_l(2, 10'h1FE, 1); drv_r(2, 10'h1FF, 1); step(); check("R7", 0, 0);
        drv_l(2, LO, 1); drv_r(2, HI, 1); step(); check("R5", 1, 1);
    endtask

    task automatic t_same_cycle();
        drv_l(1, HI, 1); drv_r(2, HI, 1); step(); check("R8", 1, 0);
        drv_l(1, HI, 1); drv_r(2, HI, 1); step(); check("R8", 1, 0);
        drv_r(1, LO, 1); drv_l(2, LO, 1); step(); check("R8", 0, 0);
        drv_r(2, HI, 1); drv_l(2, LO, 1); step(); check("R3", 1, 1);
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        t_reset();
        t_left_to_right();
        t_right_to_left();
        t_busy();
        t_other();
        t_same_cycle();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule